// File: doc/BRIEF.md
# Shared Dual-RAM March Self-Test Controller

This block is a built-in self-test engine for two on-chip RAMs that have the same shape, for example an instruction cache array and a data cache array. A single engine serves both arrays. Two select inputs choose the array under test, and only one of them may be active. After a start pulse the engine generates every access by itself: the write strobe, the read strobe, the address and the data word. It walks a March C- pattern over the whole address space.

Each word read back is checked against its expected value in the cycle it returns. The word is also folded into a signature register. At the end the signature is compared with an on-chip expected value held in a parameter. The outcome appears on a done flag and a fail flag.

The address of the first miscompare is latched. While the engine is idle it can be clocked out serially, most significant bit first.

Top module: `dual_ram_march_bist`

## Requirements
- R1: After reset, done, fail and sel_err are 0, and no read or write strobe is active on either RAM.
- R2: A start seen while idle with both selects high, or with neither high, starts nothing. sel_err becomes 1 one cycle later, no strobe is issued, and done keeps its value. sel_err returns to 0 when a start with exactly one select is accepted.
- R3: During a test, strobes go only to the RAM chosen at start (sel_a gives RAM A, sel_b gives RAM B). The other RAM's strobes stay at 0.
- R4: The sequence has N = 2^AW addresses and takes 10N accesses, one per cycle. The elements run in this order:
  - write all-zero words, ascending;
  - read all-zero then write all-ones at each address, ascending;
  - read all-ones then write all-zero, ascending;
  - read all-zero then write all-ones, descending;
  - read all-ones then write all-zero, descending;
  - read all-zero, ascending.
- R5: done rises exactly 10N+2 clock edges after the edge that accepts start. No strobe is active while done is 1.
- R6: A read word that differs from its expected all-zero or all-ones value makes fail equal to 1 when done rises.
- R7: Only the first miscompare's address is captured, and later miscompares do not change it. While idle, each cycle with shift_en high shifts the captured address one place toward the MSB. shift_out always shows the current MSB, so the address leaves MSB first.
- R8: The signature starts at 0 at each accepted start. Each returned read word d updates it as sig = {sig[DW-2:0],0} ^ (sig[DW-1] ? POLY : 0) ^ d. fail is also 1 when the final signature differs from EXP_SIG, even if no single read miscompared. fail is 0 when there is no miscompare and the signature matches.
- R9: A start seen while a test is running has no effect on the sequence, its length or its result.
- R10: A read and a write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, used only when idle |
| sel_a | input | 1 | Select RAM A for the test |
| sel_b | input | 1 | Select RAM B for the test |
| ram_a_we | output | 1 | Write strobe to RAM A |
| ram_a_re | output | 1 | Read strobe to RAM A (data returns next cycle) |
| ram_a_rdata | input | DW | Read data from RAM A |
| ram_b_we | output | 1 | Write strobe to RAM B |
| ram_b_re | output | 1 | Read strobe to RAM B (data returns next cycle) |
| ram_b_rdata | input | DW | Read data from RAM B |
| ram_addr | output | AW | Address shared by both RAMs |
| ram_wdata | output | DW | Write data shared by both RAMs |
| done | output | 1 | Test finished |
| fail | output | 1 | Test failed (valid while done is 1) |
| sel_err | output | 1 | Start refused because the select inputs were invalid |
| shift_en | input | 1 | Shift the captured fail address while idle |
| shift_out | output | 1 | Serial output of the captured fail address, MSB first |

## Verification
Two functions can coincide in one cycle. The comparison of the final read word happens while the engine is already draining toward done. A start pulse can also arrive while a sequence is still running.

The bench corrupts read words at random read indices. It also runs directed cases that corrupt only the very first read, the first read of a descending element, or only the very last read. It then judges fail and the serially unloaded address against a model that maps each read index to its address.

Extra start pulses are thrown into random cycles of running tests. The bench expects the exact done latency and an unchanged access sequence.

// File: rtl/dual_ram_march_bist.sv
module dual_ram_march_bist #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter logic [DW-1:0] POLY = 'h1D,
  parameter logic [DW-1:0] EXP_SIG = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sel_a,
  input  logic          sel_b,
  output logic          ram_a_we,
  output logic          ram_a_re,
  input  logic [DW-1:0] ram_a_rdata,
  output logic          ram_b_we,
  output logic          ram_b_re,
  input  logic [DW-1:0] ram_b_rdata,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          done,
  output logic          fail,
  output logic          sel_err,
  input  logic          shift_en,
  output logic          shift_out
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  typedef enum logic [1:0] {IDLE, RUN, DRAIN, CHECK} st_t;
  st_t st;

  logic [2:0]    elem;
  logic          ph, tgt, mis, rd_v, rd_e;
  logic [AW-1:0] addr, rd_a, cap;
  logic [DW-1:0] sig;

  wire two_op = (elem >= 3'd1) && (elem <= 3'd4);
  wire desc   = (elem == 3'd3) || (elem == 3'd4);
  wire is_rd  = (two_op && !ph) || (elem == 3'd5);
  wire rbit   = (elem == 3'd2) || (elem == 3'd4);
  wire wbit   = two_op && ((elem == 3'd1) || (elem == 3'd3));
  wire at_end = desc ? (addr == '0) : (addr == LAST);
  wire run    = (st == RUN);
  wire sel_ok = sel_a ^ sel_b;

  wire [DW-1:0] rdata  = tgt ? ram_b_rdata : ram_a_rdata;
  wire          miss   = rd_v && (rdata != {DW{rd_e}});
  wire [DW-1:0] sig_nx = {sig[DW-2:0], 1'b0} ^ (sig[DW-1] ? POLY : '0) ^ rdata;

  assign ram_a_we  = run && !is_rd && !tgt;
  assign ram_b_we  = run && !is_rd &&  tgt;
  assign ram_a_re  = run &&  is_rd && !tgt;
  assign ram_b_re  = run &&  is_rd &&  tgt;
  assign ram_addr  = addr;
  assign ram_wdata = {DW{wbit}};
  assign shift_out = cap[AW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; elem <= '0; ph <= 1'b0; addr <= '0; tgt <= 1'b0;
      sig <= '0; mis <= 1'b0; cap <= '0; rd_v <= 1'b0; rd_a <= '0;
      rd_e <= 1'b0; done <= 1'b0; fail <= 1'b0; sel_err <= 1'b0;
    end else begin
      rd_v <= run && is_rd;
      rd_a <= addr;
      rd_e <= rbit;
      if (rd_v) begin
        sig <= sig_nx;
        if (miss && !mis) begin
          mis <= 1'b1;
          cap <= rd_a;
        end
      end
      case (st)
        IDLE: begin
          if (start && sel_ok) begin
            st <= RUN; tgt <= sel_b; elem <= '0; ph <= 1'b0; addr <= '0;
            sig <= '0; mis <= 1'b0; cap <= '0;
            done <= 1'b0; fail <= 1'b0; sel_err <= 1'b0;
          end else begin
            if (start) sel_err <= 1'b1;
            if (shift_en) cap <= {cap[AW-2:0], 1'b0};
          end
        end
        RUN: begin
          if (two_op && !ph) begin
            ph <= 1'b1;
          end else begin
            ph <= 1'b0;
            if (at_end) begin
              if (elem == 3'd5) begin
                st <= DRAIN;
              end else begin
                elem <= elem + 3'd1;
                addr <= ((elem == 3'd2) || (elem == 3'd3)) ? LAST : '0;
              end
            end else begin
              addr <= desc ? addr - 1'b1 : addr + 1'b1;
            end
          end
        end
        DRAIN: st <= CHECK;
        default: begin
          done <= 1'b1;
          fail <= mis || (sig != EXP_SIG);
          st   <= IDLE;
        end
      endcase
    end
  end
endmodule

module bist_assert_chk #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_we,
  input logic          a_re,
  input logic          b_we,
  input logic          b_re,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          done,
  input logic          fail,
  input logic          sel_err
);
  wire any_we = a_we || b_we;
  wire any_re = a_re || b_re;
  wire any_st = any_we || any_re;

  // R10
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(any_we && any_re));
  // R3
  one_ram_chk: assert property (@(posedge clk) disable iff (!rst_n) !((a_we || a_re) && (b_we || b_re)));
  // R5
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !any_st);
  // R2
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) sel_err |-> !any_st);
  // R4
  solid_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_we |-> ((wdata == '0) || (wdata == '1)));
  // R6
  fail_done_chk: assert property (@(posedge clk) disable iff (!rst_n) fail |-> done);
  // R4
  addr_known_chk: assert property (@(posedge clk) disable iff (!rst_n) any_st |-> !$isunknown(addr));
endmodule

bind dual_ram_march_bist bist_assert_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_we(ram_a_we), .a_re(ram_a_re), .b_we(ram_b_we),
  .b_re(ram_b_re), .addr(ram_addr), .wdata(ram_wdata), .done(done), .fail(fail),
  .sel_err(sel_err)
);

// File: tb/sim_dual_ram_march_bist.sv
`timescale 1ns/1ps
module sim_dual_ram_march_bist;
  localparam int AW = 4, DW = 8, N = 1 << AW, NR = 5 * N, LAT = 10 * N + 2;
  localparam logic [DW-1:0] POLY = 'h1D;

  function automatic logic [DW-1:0] sig_ref();
    logic [DW-1:0] s = '0;
    for (int e = 1; e <= 5; e++)
      for (int p = 0; p < N; p++)
        s = {s[DW-2:0], 1'b0} ^ (s[DW-1] ? POLY : '0) ^ (((e == 2) || (e == 4)) ? {DW{1'b1}} : {DW{1'b0}});
    return s;
  endfunction
  localparam logic [DW-1:0] EXP = sig_ref();

  function automatic int addr_of_read(int r);
    int e = r / N + 1;
    int p = r % N;
    return ((e == 3) || (e == 4)) ? N - 1 - p : p;
  endfunction

  function automatic void op_of(input int k, output bit w, output int a, output bit d);
    if (k < N) begin
      w = 1; a = k; d = 0;
    end else if (k < 9 * N) begin
      int j = k - N;
      int e = j / (2 * N) + 1;
      int q = j % (2 * N);
      int p = q / 2;
      a = ((e == 3) || (e == 4)) ? N - 1 - p : p;
      w = (q % 2) == 1;
      d = w ? ((e == 1) || (e == 3)) : ((e == 2) || (e == 4));
    end else begin
      w = 0; a = k - 9 * N; d = 0;
    end
  endfunction

  logic clk = 0, rst_n = 0, start = 0, sel_a = 0, sel_b = 0, shift_en = 0;
  logic a_we, a_re, b_we, b_re, done, fail, sel_err, shift_out;
  logic [DW-1:0] a_rd, b_rd, wdata;
  logic [AW-1:0] addr;
  always #2.5 clk = ~clk;

  dual_ram_march_bist #(.AW(AW), .DW(DW), .POLY(POLY), .EXP_SIG(EXP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_a(sel_a), .sel_b(sel_b),
    .ram_a_we(a_we), .ram_a_re(a_re), .ram_a_rdata(a_rd),
    .ram_b_we(b_we), .ram_b_re(b_re), .ram_b_rdata(b_rd),
    .ram_addr(addr), .ram_wdata(wdata), .done(done), .fail(fail),
    .sel_err(sel_err), .shift_en(shift_en), .shift_out(shift_out));

  logic start1 = 0, shift1 = 0;
  logic w1, r1, bw1, br1, done1, fail1, err1, so1;
  logic [DW-1:0] rd1, wd1;
  logic [AW-1:0] ad1;
  dual_ram_march_bist #(.AW(AW), .DW(DW), .POLY(POLY), .EXP_SIG(EXP ^ 8'h01)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start1), .sel_a(1'b1), .sel_b(1'b0),
    .ram_a_we(w1), .ram_a_re(r1), .ram_a_rdata(rd1),
    .ram_b_we(bw1), .ram_b_re(br1), .ram_b_rdata(8'h00),
    .ram_addr(ad1), .ram_wdata(wd1), .done(done1), .fail(fail1),
    .sel_err(err1), .shift_en(shift1), .shift_out(so1));

  logic [DW-1:0] mem_a [N], mem_b [N], mem1 [N];
  logic [NR-1:0] corrupt = '0;
  logic [DW-1:0] mask = 8'h01;
  int rdn = 0, k = 0, seq_bad = 0, wrong = 0;
  bit tsel_b = 0;
  int checks = 0, errors = 0;

  always @(posedge clk) begin
    if (a_we) mem_a[addr] <= wdata;
    if (b_we) mem_b[addr] <= wdata;
    if (a_re) a_rd <= mem_a[addr] ^ (corrupt[rdn] ? mask : '0);
    if (b_re) b_rd <= mem_b[addr] ^ (corrupt[rdn] ? mask : '0);
    if (a_re || b_re) rdn <= rdn + 1;
    if (w1) mem1[ad1] <= wd1;
    if (r1) rd1 <= mem1[ad1];
  end

  always @(negedge clk) begin
    if (a_we || a_re || b_we || b_re) begin
      bit w, d;
      int a;
      if (tsel_b ? (a_we || a_re) : (b_we || b_re)) wrong++;
      if (k >= 10 * N) seq_bad++;
      else begin
        op_of(k, w, a, d);
        if ((a_we || b_we) != w || (a_re || b_re) == w || int'(addr) != a) seq_bad++;
        if (w && wdata != {DW{d}}) seq_bad++;
      end
      k++;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic unload(output logic [AW-1:0] got);
    for (int i = 0; i < AW; i++) begin
      got[AW-1-i] = shift_out;
      shift_en = 1;
      @(negedge clk);
    end
    shift_en = 0;
  endtask

  task automatic run_test(bit useb, logic [NR-1:0] cor, int restart_at);
    int cyc = 0, first = -1;
    logic [AW-1:0] got;
    corrupt = cor;
    mask = 8'($urandom_range(1, 255));
    tsel_b = useb; k = 0; seq_bad = 0; wrong = 0; rdn = 0;
    for (int i = NR - 1; i >= 0; i--) if (cor[i]) first = i;
    sel_a = !useb; sel_b = useb; start = 1;
    @(negedge clk);
    start = 0;
    while (!done && cyc < 1000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      start = (cyc == restart_at);
    end
    start = 0;
    chk(cyc == LAT, "R5/R9 latency", cyc, LAT);
    chk(k == 10 * N && seq_bad == 0, "R4 sequence", seq_bad, 0);
    chk(wrong == 0, "R3 unselected RAM touched", wrong, 0);
    chk(fail == (first >= 0), "R6/R8 fail flag", fail, first >= 0);
    chk(sel_err == 0, "R2 err cleared", sel_err, 0);
    if (first >= 0) begin
      unload(got);
      chk(int'(got) == addr_of_read(first), "R7 captured address", got, addr_of_read(first));
      chk(done && fail, "R7 flags hold after unload", {done, fail}, 3);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] got;
    logic [NR-1:0] c;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1
    chk(!done && !fail && !sel_err, "R1 reset flags", {done, fail, sel_err}, 0);
    chk(!(a_we || a_re || b_we || b_re), "R1 reset strobes", 1, 0);
    rst_n = 1;
    @(negedge clk);
    // R2 both selects, then neither
    k = 0;
    sel_a = 1; sel_b = 1; start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    chk(sel_err && !done && k == 0, "R2 both selected", {sel_err, done}, 2);
    sel_a = 0; sel_b = 0; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
    chk(sel_err && k == 0, "R2 none selected", sel_err, 1);
    // R8 clean run on each RAM
    run_test(0, '0, 0);
    run_test(1, '0, 0);
    // R2 after done: done kept
    sel_a = 1; sel_b = 1; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
    chk(sel_err && done, "R2 done kept", {sel_err, done}, 3);
    // R7 directed fault positions
    c = '0; c[0] = 1; run_test(0, c, 0);
    c = '0; c[2 * N] = 1; run_test(1, c, 0);
    c = '0; c[NR - 1] = 1; run_test(0, c, 0);
    // R7 later fault after an earlier one
    c = '0; c[N + 3] = 1; c[4 * N + 1] = 1; run_test(1, c, 0);
    // R9 random runs with restart pulses
    for (int t = 0; t < 12; t++) begin
      c = '0;
      for (int i = 0; i < int'($urandom_range(0, 3)); i++) c[$urandom_range(0, NR - 1)] = 1;
      run_test(1'($urandom_range(0, 1)), c, int'($urandom_range(1, LAT - 10)));
    end
    // R8 signature mismatch without miscompare
    start1 = 1;
    @(negedge clk); start1 = 0;
    for (int i = 0; i < 1000 && !done1; i++) @(negedge clk);
    chk(done1 && fail1, "R8 signature mismatch", fail1, 1);
    for (int i = 0; i < AW; i++) begin
      got[AW-1-i] = so1; shift1 = 1; @(negedge clk);
    end
    shift1 = 0;
    chk(got == '0, "R7 no capture without miscompare", got, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule